// File: doc/BRIEF.md
# Buffer Descriptor Chain Walker

This block follows a linked list of buffer descriptors for one DMA channel. Every descriptor takes 16 bytes in a contiguous area in host memory. A slot's address comes from a base pointer and a 16-bit slot index. The walker reads each descriptor as four 32-bit words over a valid/ready memory port, and reads the two-bit sync code in that descriptor.

A descriptor marked ready is checked. If it passes, the walker hands its buffer address, length and end-of-frame flag to a data mover. While the mover works, the walker prefetches the linked descriptor. When the mover reports that it has finished, the walker writes a status code back into the finished descriptor:

- "done, link valid" if the prefetched successor was ready. The walker then hands the successor on at once.
- "done, link invalid" otherwise. The walker then parks on the successor's slot.

A parked walk reads memory again only after a resume pulse from software. A descriptor that fails its check sets an error flag and halts the walk until the next start.

Top module: `dchain_walker`

## Requirements
- R1: A slot address is the base pointer with its low four bits cleared, plus the slot index times 16. A descriptor is read as four word reads at slot+0, +4, +8 and +12, in that order.
- R2: Word layout:
  - slot+0: buffer address, low word.
  - slot+4: buffer address, high word.
  - slot+8: sync code in bits 31:30, end-of-frame in bit 29, length in bits 15:0.
  - slot+12: link index in bits 15:0.
- R3: Only sync code 3 (ready) is processed. Codes 0, 1 and 2 park the walk: no request is issued until a resume pulse, and then the same slot is read again.
- R4: A usable descriptor is offered to the mover with its low address word, length and end-of-frame flag. mv_valid and these values stay stable until mv_ready.
- R5: A ready descriptor with a non-zero high address word or a zero length sets walk_err. The walk then halts with no offer and no further memory request. A later start clears walk_err and walks again.
- R6: Once an offer is accepted, the linked descriptor is read from memory before any write-back.
- R7: Write-back is one word write to slot+8 of the finished descriptor. It keeps bits 29:0 and puts code 0 in bits 31:30 if the prefetched successor reads ready, or code 1 otherwise.
- R8: Write-back happens only after the mover's mv_done pulse for that descriptor.
- R9: A successor that is ready when prefetched is offered after write-back without being read again, so each slot of a ready chain is read exactly once.
- R10: After reset no memory request and no offer are issued, and walk_err is 0.
- R11: A start pulse is ignored unless the walker is idle or halted by an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_ptr | input | AW | Descriptor area base address |
| start | input | 1 | Begin a walk at start_idx |
| start_idx | input | 16 | First slot index |
| resume | input | 1 | Re-poll the parked slot |
| req_valid | output | 1 | Memory request valid |
| req_ready | input | 1 | Memory request accepted |
| req_write | output | 1 | 1 = word write, 0 = word read |
| req_addr | output | AW | Byte address of the word |
| req_wdata | output | 32 | Write data |
| rsp_valid | input | 1 | Read data valid |
| rsp_data | input | 32 | Read data |
| mv_valid | output | 1 | Buffer offer valid |
| mv_ready | input | 1 | Mover accepts the offer |
| mv_addr | output | 32 | Buffer address |
| mv_len | output | 16 | Buffer length in bytes |
| mv_eof | output | 1 | Buffer ends a frame |
| mv_done | input | 1 | Mover finished the buffer |
| walk_err | output | 1 | Descriptor check failed, walk halted |

## Verification
On every cycle the assertions check that:
- an offer holds stable under back-pressure;
- a parked or halted walker stays silent on both ports;
- reads are word aligned and held until accepted;
- write-backs land only on the status word, and only after the mover has finished.

The status code that is written, the read-once rule for a ready chain, the address arithmetic at the top of the index range, the reuse of the same slot after resume, and the ignored start can only be shown by the bench scenarios. The bench shows them by comparing the logged memory traffic and offers with values it computes from the descriptors it placed.

// File: rtl/dchain_pkg.sv
package dchain_pkg;
  localparam int WORD_W      = 32;
  localparam int LEN_W       = 16;
  localparam int IDX_W       = 16;
  localparam int BEATS       = 4;
  localparam int STRIDE_LOG2 = 4;

  typedef enum logic [1:0] {
    SY_DONE_LINKED   = 2'd0,
    SY_DONE_UNLINKED = 2'd1,
    SY_HOLD          = 2'd2,
    SY_GO            = 2'd3
  } sync_e;

  typedef struct packed {
    logic [WORD_W-1:0] buf_lo;
    logic [WORD_W-1:0] buf_hi;
    logic [1:0]        sync;
    logic              eof;
    logic [12:0]       spare;
    logic [LEN_W-1:0]  len;
    logic [IDX_W-1:0]  link;
  } desc_t;

  // word k of the descriptor sits in bits [k*32 +: 32]
  function automatic desc_t unpack_desc(input logic [BEATS*WORD_W-1:0] w);
    desc_t d;
    d.buf_lo = w[31:0];
    d.buf_hi = w[63:32];
    {d.sync, d.eof, d.spare, d.len} = w[95:64];
    d.link = w[111:96];
    return d;
  endfunction

  function automatic logic [WORD_W-1:0] status_word(input desc_t d, input logic [1:0] code);
    return {code, d.eof, d.spare, d.len};
  endfunction

  function automatic logic sync_go(input logic [1:0] s);
    return s == SY_GO;
  endfunction
endpackage

// File: rtl/dchain_fetch.sv
module dchain_fetch
  import dchain_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [AW-1:0]     start_addr,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [AW-1:0]     rd_addr,
  input  logic              rsp_valid,
  input  logic [WORD_W-1:0] rsp_data,
  output logic              done,
  output desc_t             desc
);
  localparam int BW = $clog2(BEATS);

  logic                    active, waiting;
  logic [BW-1:0]           beat;
  logic [AW-1:0]           base_q;
  logic [BEATS*WORD_W-1:0] words;
  logic                    last_beat;

  assign last_beat = (beat == BW'(BEATS - 1));
  assign rd_valid  = active && !waiting;
  assign rd_addr   = base_q + AW'({beat, 2'b00});
  assign desc      = unpack_desc(words);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      waiting <= 1'b0;
      beat    <= '0;
      base_q  <= '0;
      words   <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go && !active) begin
        active  <= 1'b1;
        waiting <= 1'b0;
        beat    <= '0;
        base_q  <= start_addr;
      end else if (active) begin
        if (!waiting && rd_ready) waiting <= 1'b1;
        if (waiting && rsp_valid) begin
          words[beat*WORD_W +: WORD_W] <= rsp_data;
          waiting <= 1'b0;
          if (last_beat) begin
            active <= 1'b0;
            done   <= 1'b1;
          end else begin
            beat <= beat + 1'b1;
          end
        end
      end
    end
  end

  a_r1_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> rd_addr[1:0] == 2'b00);
  a_r1_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr));
  a_r1_no_overlap_go: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !active);
endmodule

// File: rtl/dchain_check.sv
module dchain_check
  import dchain_pkg::*;
(
  input  desc_t d,
  output logic  is_go,
  output logic  is_bad
);
  assign is_go  = sync_go(d.sync);
  assign is_bad = (d.buf_hi != '0) || (d.len == '0);
endmodule

// File: rtl/dchain_walker.sv
module dchain_walker
  import dchain_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     base_ptr,
  input  logic              start,
  input  logic [IDX_W-1:0]  start_idx,
  input  logic              resume,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_write,
  output logic [AW-1:0]     req_addr,
  output logic [WORD_W-1:0] req_wdata,
  input  logic              rsp_valid,
  input  logic [WORD_W-1:0] rsp_data,
  output logic              mv_valid,
  input  logic              mv_ready,
  output logic [WORD_W-1:0] mv_addr,
  output logic [LEN_W-1:0]  mv_len,
  output logic              mv_eof,
  input  logic              mv_done,
  output logic              walk_err
);
  localparam logic [AW-1:0] STATUS_OFS = AW'(8);
  localparam logic [AW-1:0] ALIGN_MASK = ~AW'((1 << STRIDE_LOG2) - 1);

  typedef enum logic [3:0] {
    ST_IDLE, ST_FETCH, ST_EVAL, ST_PARK, ST_OFFER,
    ST_PREF, ST_WAITD, ST_WBACK, ST_HALT
  } st_e;

  function automatic logic [AW-1:0] slot_addr(input logic [AW-1:0] b, input logic [IDX_W-1:0] i);
    return (b & ALIGN_MASK) + (AW'(i) << STRIDE_LOG2);
  endfunction

  st_e             st;
  logic [IDX_W-1:0] cur_idx;
  desc_t           cur_d, nxt_d, f_desc;
  logic            done_seen;
  logic            cur_go, cur_bad, nxt_go;
  logic            fetch_go, f_done, f_rd_valid, wb_valid;
  logic [AW-1:0]   fetch_addr, f_rd_addr;

  dchain_fetch #(.AW(AW)) u_fetch (
    .clk(clk), .rst_n(rst_n), .go(fetch_go), .start_addr(fetch_addr),
    .rd_valid(f_rd_valid), .rd_ready(req_ready), .rd_addr(f_rd_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .done(f_done), .desc(f_desc)
  );

  dchain_check u_check (.d(cur_d), .is_go(cur_go), .is_bad(cur_bad));

  assign nxt_go   = sync_go(nxt_d.sync);
  assign wb_valid = (st == ST_WBACK);
  assign mv_valid = (st == ST_OFFER);
  assign mv_addr  = cur_d.buf_lo;
  assign mv_len   = cur_d.len;
  assign mv_eof   = cur_d.eof;

  assign req_valid = f_rd_valid || wb_valid;
  assign req_write = wb_valid;
  assign req_addr  = wb_valid ? slot_addr(base_ptr, cur_idx) + STATUS_OFS : f_rd_addr;
  assign req_wdata = wb_valid ? status_word(cur_d, nxt_go ? 2'd0 : 2'd1) : '0;

  always_comb begin
    fetch_go   = 1'b0;
    fetch_addr = slot_addr(base_ptr, cur_idx);
    case (st)
      ST_IDLE, ST_HALT: if (start) begin
        fetch_go   = 1'b1;
        fetch_addr = slot_addr(base_ptr, start_idx);
      end
      ST_PARK:  fetch_go = resume;
      ST_OFFER: if (mv_ready) begin
        fetch_go   = 1'b1;
        fetch_addr = slot_addr(base_ptr, cur_d.link);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      cur_idx   <= '0;
      cur_d     <= '0;
      nxt_d     <= '0;
      done_seen <= 1'b0;
      walk_err  <= 1'b0;
    end else begin
      if (mv_done && (st == ST_PREF || st == ST_WAITD)) done_seen <= 1'b1;
      case (st)
        ST_IDLE, ST_HALT: if (start) begin
          cur_idx  <= start_idx;
          walk_err <= 1'b0;
          st       <= ST_FETCH;
        end
        ST_FETCH: if (f_done) begin
          cur_d <= f_desc;
          st    <= ST_EVAL;
        end
        ST_EVAL: begin
          if (!cur_go) st <= ST_PARK;
          else if (cur_bad) begin
            walk_err <= 1'b1;
            st       <= ST_HALT;
          end else st <= ST_OFFER;
        end
        ST_PARK:  if (resume) st <= ST_FETCH;
        ST_OFFER: if (mv_ready) st <= ST_PREF;
        ST_PREF: if (f_done) begin
          nxt_d <= f_desc;
          st    <= ST_WAITD;
        end
        ST_WAITD: if (done_seen) st <= ST_WBACK;
        ST_WBACK: if (req_ready) begin
          cur_idx   <= cur_d.link;
          done_seen <= 1'b0;
          if (nxt_go) begin
            cur_d <= nxt_d;
            st    <= ST_EVAL;
          end else st <= ST_PARK;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  a_r4_offer_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mv_valid && !mv_ready |=> mv_valid && $stable(mv_addr) && $stable(mv_len) && $stable(mv_eof));
  a_r3_park_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_PARK |-> !req_valid && !mv_valid);
  a_r5_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    walk_err |-> !req_valid && !mv_valid);
  a_r5_offer_len: assert property (@(posedge clk) disable iff (!rst_n)
    mv_valid |-> mv_len != '0);
  a_r7_status_slot: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write |-> req_addr[3:0] == 4'h8 && req_wdata[31:30] != 2'd2 && req_wdata[31:30] != 2'd3);
  a_r8_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write |-> done_seen);
  a_r6_single_master: assert property (@(posedge clk) disable iff (!rst_n)
    !(f_rd_valid && wb_valid));
endmodule

// File: tb/sim_dchain_walker.sv
module sim_dchain_walker;
  import dchain_pkg::*;
  localparam int AW = 32;

  typedef struct packed {
    logic [1:0]  sync;
    logic [31:0] hi;
    logic [15:0] len;
    logic        eof;
    logic [1:0]  kind;   // 0 offered, 1 parked, 2 error
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{2'd3, 32'd0, 16'h0040, 1'b1, 2'd0},
    '{2'd3, 32'd0, 16'h0001, 1'b0, 2'd0},
    '{2'd2, 32'd0, 16'h0040, 1'b0, 2'd1},
    '{2'd0, 32'd0, 16'h0040, 1'b0, 2'd1},
    '{2'd1, 32'd0, 16'h0040, 1'b1, 2'd1},
    '{2'd3, 32'd1, 16'h0040, 1'b0, 2'd2},
    '{2'd3, 32'd0, 16'h0000, 1'b1, 2'd2}
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, start = 1'b0, resume = 1'b0, req_ready = 1'b1, mv_ready = 1'b1;
  logic [AW-1:0] base_ptr = 32'h0000_4000;
  logic [15:0] start_idx = '0;
  logic req_valid, req_write, rsp_valid, mv_valid, mv_eof, mv_done, walk_err;
  logic [AW-1:0] req_addr;
  logic [31:0] req_wdata, rsp_data, mv_addr;
  logic [15:0] mv_len;

  dchain_walker #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .base_ptr(base_ptr), .start(start), .start_idx(start_idx),
    .resume(resume), .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .mv_valid(mv_valid), .mv_ready(mv_ready), .mv_addr(mv_addr), .mv_len(mv_len),
    .mv_eof(mv_eof), .mv_done(mv_done), .walk_err(walk_err)
  );

  logic [31:0] mem [logic [31:0]];
  logic [31:0] rd_log[$], wa_log[$], wd_log[$], ho_a[$];
  logic [15:0] ho_l[$];
  logic        ho_e[$];
  int done_delay = 5;
  int done_cnt = 0;
  int total = 0, bad = 0, cyc = 0;

  function automatic logic [31:0] peek(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0; rsp_data <= '0; mv_done <= 1'b0; done_cnt <= 0;
    end else begin
      rsp_valid <= 1'b0;
      mv_done   <= 1'b0;
      if (req_valid && req_ready) begin
        if (req_write) begin
          mem[req_addr] = req_wdata;
          wa_log.push_back(req_addr); wd_log.push_back(req_wdata);
        end else begin
          rd_log.push_back(req_addr);
          rsp_valid <= 1'b1; rsp_data <= peek(req_addr);
        end
      end
      if (mv_valid && mv_ready) begin
        ho_a.push_back(mv_addr); ho_l.push_back(mv_len); ho_e.push_back(mv_eof);
        done_cnt <= done_delay;
      end else if (done_cnt != 0) begin
        done_cnt <= done_cnt - 1;
        if (done_cnt == 1) mv_done <= 1'b1;
      end
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      bad = bad + 1; total = total + 1;
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; start = 1'b0; resume = 1'b0; mv_ready = 1'b1; done_delay = 5;
    tick(3); rst_n = 1'b1; tick(1);
    rd_log.delete(); wa_log.delete(); wd_log.delete();
    ho_a.delete(); ho_l.delete(); ho_e.delete(); mem.delete();
  endtask

  function automatic logic [31:0] slot(input logic [31:0] b, input int idx);
    return (b & 32'hFFFF_FFF0) + 32'(idx) * 32'd16;
  endfunction

  task automatic put_desc(input int idx, input logic [31:0] lo, input logic [31:0] hi,
                          input logic [1:0] sy, input logic eof, input logic [15:0] len, input int link);
    logic [31:0] a;
    a = slot(base_ptr, idx);
    mem[a] = lo; mem[a+4] = hi;
    mem[a+8] = {sy, eof, 13'h0, len};
    mem[a+12] = {16'h0, 16'(link)};
  endtask

  task automatic kick(input int idx);
    start = 1'b1; start_idx = 16'(idx); tick(1); start = 1'b0;
  endtask

  task automatic poke_resume();
    resume = 1'b1; tick(1); resume = 1'b0;
  endtask

  initial begin
    logic [31:0] a3, a7, lo;
    do_reset();
    // R10: quiet after reset
    chk(!req_valid && !mv_valid && !walk_err, "R10 reset state",
        {29'h0, req_valid, mv_valid, walk_err}, 32'h0);

    // vector table: one descriptor at slot 3 linking to a held slot 7
    for (int i = 0; i < 7; i++) begin
      do_reset();
      base_ptr = 32'h0000_4000;
      a3 = slot(base_ptr, 3); a7 = slot(base_ptr, 7);
      lo = 32'hA000_0000 + 32'(i) * 32'h100;
      put_desc(3, lo, VECS[i].hi, VECS[i].sync, VECS[i].eof, VECS[i].len, 7);
      put_desc(7, 32'h0, 32'h0, 2'd2, 1'b0, 16'h10, 0);
      kick(3);
      tick(60);
      chk(rd_log[0] == a3 && rd_log[3] == a3 + 12, "R1 slot read order", rd_log[3], a3 + 12);
      case (VECS[i].kind)
        2'd0: begin
          chk(ho_a.size() == 1 && ho_a[0] == lo && ho_l[0] == VECS[i].len && ho_e[0] == VECS[i].eof,
              "R4 offer fields", ho_a[0], lo);
          chk(rd_log.size() == 8 && rd_log[4] == a7, "R6 successor prefetch", rd_log[4], a7);
          chk(wa_log.size() == 1 && wa_log[0] == a3 + 8 &&
              wd_log[0] == {2'd1, VECS[i].eof, 13'h0, VECS[i].len},
              "R7 write-back unlinked", wd_log[0], {2'd1, VECS[i].eof, 13'h0, VECS[i].len});
        end
        2'd1: begin
          chk(ho_a.size() == 0 && rd_log.size() == 4 && wa_log.size() == 0, "R3 parked quiet",
              32'(rd_log.size()), 32'd4);
          poke_resume(); tick(30);
          chk(rd_log.size() == 8 && rd_log[4] == a3, "R3 re-poll same slot", rd_log[4], a3);
        end
        default: begin
          chk(walk_err && ho_a.size() == 0 && rd_log.size() == 4, "R5 error halt",
              {31'h0, walk_err}, 32'h1);
        end
      endcase
    end

    // R5: start after error clears the flag and walks again
    put_desc(9, 32'hB000_0000, 32'h0, 2'd3, 1'b1, 16'h0030, 7);
    kick(9); tick(2);
    chk(!walk_err, "R5 start clears error", {31'h0, walk_err}, 32'h0);
    tick(60);
    chk(ho_a.size() == 1 && ho_a[0] == 32'hB000_0000, "R5 walk resumes after restart",
        ho_a[0], 32'hB000_0000);

    // R9 / R7: ready chain 0 -> 1 -> 2 -> 3 (held)
    do_reset();
    put_desc(0, 32'hC000_0000, 32'h0, 2'd3, 1'b0, 16'h0100, 1);
    put_desc(1, 32'hC000_1000, 32'h0, 2'd3, 1'b0, 16'h0200, 2);
    put_desc(2, 32'hC000_2000, 32'h0, 2'd3, 1'b1, 16'h0300, 3);
    put_desc(3, 32'hC000_3000, 32'h0, 2'd2, 1'b0, 16'h0400, 0);
    kick(0); tick(150);
    chk(ho_a.size() == 3 && ho_a[0] == 32'hC000_0000 && ho_a[1] == 32'hC000_1000 &&
        ho_a[2] == 32'hC000_2000 && ho_e[2] == 1'b1, "R4 chain offers in order",
        32'(ho_a.size()), 32'd3);
    chk(rd_log.size() == 16, "R9 each slot read once", 32'(rd_log.size()), 32'd16);
    chk(wd_log.size() == 3 && wd_log[0] == {2'd0, 1'b0, 13'h0, 16'h0100} &&
        wd_log[1] == {2'd0, 1'b0, 13'h0, 16'h0200}, "R7 linked write-back", wd_log[1],
        {2'd0, 1'b0, 13'h0, 16'h0200});
    chk(wd_log[2] == {2'd1, 1'b1, 13'h0, 16'h0300} && wa_log[2] == slot(base_ptr, 2) + 8,
        "R7 last write-back unlinked", wd_log[2], {2'd1, 1'b1, 13'h0, 16'h0300});
    // R11: start while parked is ignored
    kick(0); tick(20);
    chk(rd_log.size() == 16 && ho_a.size() == 3, "R11 start ignored while parked",
        32'(rd_log.size()), 32'd16);
    put_desc(3, 32'hC000_3000, 32'h0, 2'd3, 1'b0, 16'h0400, 5);
    poke_resume(); tick(30);
    chk(rd_log.size() >= 20 && rd_log[16] == slot(base_ptr, 3) && ho_a.size() == 4 &&
        ho_a[3] == 32'hC000_3000, "R3 resume picks up parked slot", rd_log[16], slot(base_ptr, 3));

    // R8: write-back waits for the mover
    do_reset();
    done_delay = 70;
    put_desc(4, 32'hD000_0000, 32'h0, 2'd3, 1'b0, 16'h0008, 5);
    put_desc(5, 32'h0, 32'h0, 2'd2, 1'b0, 16'h0008, 0);
    kick(4); tick(50);
    chk(ho_a.size() == 1 && wa_log.size() == 0, "R8 no write-back before done",
        32'(wa_log.size()), 32'd0);
    tick(40);
    chk(wa_log.size() == 1, "R8 write-back after done", 32'(wa_log.size()), 32'd1);

    // R4: offer held while mover stalls
    do_reset();
    mv_ready = 1'b0;
    put_desc(2, 32'hE000_0040, 32'h0, 2'd3, 1'b1, 16'h0020, 5);
    kick(2); tick(40);
    chk(mv_valid && mv_addr == 32'hE000_0040 && mv_len == 16'h0020 && mv_eof &&
        rd_log.size() == 4, "R4 offer held under back-pressure", mv_addr, 32'hE000_0040);
    mv_ready = 1'b1; tick(2);
    chk(ho_a.size() == 1 && !mv_valid, "R4 offer taken once", 32'(ho_a.size()), 32'd1);

    // R1: top index, unaligned base bits ignored
    do_reset();
    base_ptr = 32'h0010_0007;
    put_desc(16'hFFFF, 32'h0, 32'h0, 2'd2, 1'b0, 16'h1, 0);
    kick(16'hFFFF); tick(30);
    chk(rd_log[0] == 32'h001F_FFF0 && rd_log[2] == 32'h001F_FFF8, "R1 top index address",
        rd_log[0], 32'h001F_FFF0);
    chk(mem[32'h001F_FFF8][31:30] == 2'd2 && ho_a.size() == 0, "R2 status word layout",
        {30'h0, mem[32'h001F_FFF8][31:30]}, 32'd2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule